// File: doc/BRIEF.md
# DMA Shadow Register Readback Unit

This unit sits beside a pair of legacy 8237-style DMA register sets, a primary controller at ports 0x00–0x1F and a secondary controller at ports 0xC0–0xDF. It watches every I/O write to those ports and keeps its own copy of settings that the controllers either never return or return only in part. For each channel it keeps the base address, the base count and the mode byte. For each controller it keeps the command byte, the request bits and the mask bits.

When `shadow_en` is high, an I/O read of a port that has a copy is answered from that copy, and `shadow_active` rises. Every other read takes its data from the real controller's `ctrl_rdata`. Writes are never redirected: the unit only observes them.

The 16-bit address and count values move one byte per access, under a byte-pointer flip-flop that each controller keeps for itself. Offset 8 of each controller acts as a read sequence port. Successive shadow reads of it return six values in turn: the command byte, the request bits, and then the mode bytes of channels 0 to 3.

Top module: `dma_shadow_readback`

## Requirements
- R1: While `shadow_en` is 0, `rd_data` equals `ctrl_rdata`, `shadow_active` is 0, and shadow reads of offset 8 do not advance the read sequence.
- R2: During a write cycle (`io_rd` low), `shadow_active` is 0 and `rd_data` equals `ctrl_rdata`.
- R3: A port is in the primary controller when address bits 15:5 are zero. Its offset is address bits 3:0, so bit 4 is ignored. A read of offset 0–7 returns one byte of channel offset/2: the base address at an even offset, the base count at an odd offset. The low byte is returned when the pointer is 0 and the high byte when it is 1.
- R4: Each controller has a byte pointer that is 0 after reset. Every read or write of offsets 0–7 toggles it, whether or not shadowing is enabled. A write to offset 0xC clears it.
- R5: A shadow read of offset 8 returns the next value in the order command, request, mode of channel 0, 1, 2, 3. After the sixth value it wraps back to command.
- R6: Any write to a controller sends that controller's read sequence back to the command step.
- R7: A write to offset 9 sets the request bit of the channel given by data bits 1:0 when data bit 2 is 1, and clears it when data bit 2 is 0. The request step returns these bits in bits 3:0, with bits 7:4 zero.
- R8: Mask bits change on four writes. Offset 0xA sets or clears the bit of the channel in data bits 1:0 according to data bit 2. Offset 0xF loads data bits 3:0. Offset 0xE clears all bits. A shadow read of offset 0xF returns the mask bits in bits 3:0, with bits 7:4 zero.
- R9: A write to offset 8 stores the whole command byte. A write to offset 0xB stores the whole byte as the mode of the channel in data bits 1:0.
- R10: A write to offset 0xD sets every mask bit, clears the command and request bits, clears the byte pointer and resets the read sequence. Base values and mode bytes are kept.
- R11: The secondary controller decodes ports 0xC0–0xDF with offset = address bits 4:1, so bit 0 is ignored. It follows the same rules as the primary controller but keeps its own state.
- R12: Reset clears every shadow value, including the mask bits, and both byte pointers and both read sequences.
- R13: Reads of offsets 9–0xE, and of addresses outside both controllers, return `ctrl_rdata` with `shadow_active` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| shadow_en | input | 1 | Enables redirection of reads to the shadow copies |
| ctrl_rdata | input | 8 | Read data from the real controllers |
| rd_data | output | 8 | Read data returned to the bus |
| shadow_active | output | 1 | High when `rd_data` comes from a shadow copy |

## Verification
Read data and `shadow_active` are combinational, so they are due in the same cycle as the read strobe. The bench drives each access at the falling edge and samples these outputs 1 ns later, before the next rising edge. A write, and the pointer or sequence step caused by a read, take effect at the next rising edge. For that reason every check that depends on earlier stimulus is made on a later access, never on the access that caused the change. Reset is checked the same way: it is released at a falling edge, and the shadow values are read on the accesses that follow.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   // Offsets within one controller's register window
   typedef enum logic [3:0] {
      OFF_CMD     = 4'h8,
      OFF_REQ     = 4'h9,
      OFF_SMASK   = 4'hA,
      OFF_MODE    = 4'hB,
      OFF_CLRPTR  = 4'hC,
      OFF_MCLR    = 4'hD,
      OFF_CLRMASK = 4'hE,
      OFF_ALLMASK = 4'hF
   } dsr_off_e;

   localparam int unsigned CTRL_N   = 2;
   localparam int unsigned OFF_W    = 4;
   localparam int unsigned CHSEL_W  = 2;
endpackage

// File: rtl/dsr_decode.sv
module dsr_decode #(
   parameter int unsigned         ADDR_W     = 16,
   parameter logic [ADDR_W-1:0]   MATCH_MASK = 16'hFFE0,
   parameter logic [ADDR_W-1:0]   MATCH_BASE = 16'h0000,
   parameter int unsigned         SHIFT      = 0
) (
   input  logic [ADDR_W-1:0]           addr,
   output logic                        hit,
   output logic [dsr_pkg::OFF_W-1:0]   off
);
   logic [ADDR_W-1:0] shifted;

   if (SHIFT > 1) begin : g_bad_shift
      $error("dsr_decode: SHIFT must be 0 or 1");
   end

   always_comb begin
      hit     = (addr & MATCH_MASK) == MATCH_BASE;
      shifted = addr >> SHIFT;
      off     = shifted[dsr_pkg::OFF_W-1:0];
   end
endmodule

// File: rtl/dsr_seq.sv
module dsr_seq #(
   parameter int unsigned LEN   = 6,
   localparam int unsigned IDX_W = $clog2(LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [IDX_W-1:0] idx
);
   if (LEN < 2) begin : g_bad_len
      $error("dsr_seq: LEN must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         idx <= '0;
      end else if (adv) begin
         idx <= (idx == IDX_W'(LEN - 1)) ? '0 : idx + 1'b1;
      end
   end
endmodule

// File: rtl/dsr_bank.sv
module dsr_bank
   import dsr_pkg::*;
#(
   parameter int unsigned CHANNELS = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned WORD_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic                rd,
   input  logic                en,
   input  logic [OFF_W-1:0]    off,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                shadow_hit
);
   localparam int unsigned SEQ_LEN = 2 + CHANNELS;
   localparam int unsigned SEQ_W   = $clog2(SEQ_LEN);
   localparam int unsigned PAIR_N  = 2 * CHANNELS;

   if (!(CHANNELS == 1 || CHANNELS == 2 || CHANNELS == 4)) begin : g_bad_ch
      $error("dsr_bank: CHANNELS must be 1, 2 or 4");
   end
   if (WORD_W != 2 * DATA_W) begin : g_bad_word
      $error("dsr_bank: WORD_W must be twice DATA_W");
   end
   if (DATA_W < 4) begin : g_bad_data
      $error("dsr_bank: DATA_W must be at least 4");
   end

   logic [WORD_W-1:0]   base_addr_q [CHANNELS];
   logic [WORD_W-1:0]   base_cnt_q  [CHANNELS];
   logic [DATA_W-1:0]   mode_q      [CHANNELS];
   logic [CHANNELS-1:0] req_q;
   logic [CHANNELS-1:0] mask_q;
   logic [DATA_W-1:0]   cmd_q;
   logic                ptr_q;
   logic [SEQ_W-1:0]    seq_idx;

   logic                pair_sel;
   logic [CHSEL_W-1:0]  pair_ch;
   logic                pair_cnt;
   logic [CHSEL_W-1:0]  data_ch;
   logic                data_bit;
   logic                is_mclr;

   always_comb begin
      pair_sel = off < OFF_W'(PAIR_N);
      pair_ch  = off[CHSEL_W:1];
      pair_cnt = off[0];
      data_ch  = wdata[CHSEL_W-1:0];
      data_bit = wdata[CHSEL_W];
      is_mclr  = wr && (off == OFF_MCLR);
   end

   // Per-channel storage
   for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_addr_q[c] <= '0;
            base_cnt_q[c]  <= '0;
            mode_q[c]      <= '0;
            req_q[c]       <= 1'b0;
            mask_q[c]      <= 1'b0;
         end else if (wr) begin
            if (pair_sel && pair_ch == CHSEL_W'(c)) begin
               if (pair_cnt) begin
                  if (ptr_q) base_cnt_q[c][WORD_W-1:DATA_W] <= wdata;
                  else       base_cnt_q[c][DATA_W-1:0]      <= wdata;
               end else begin
                  if (ptr_q) base_addr_q[c][WORD_W-1:DATA_W] <= wdata;
                  else       base_addr_q[c][DATA_W-1:0]      <= wdata;
               end
            end
            if (off == OFF_MODE && data_ch == CHSEL_W'(c)) begin
               mode_q[c] <= wdata;
            end
            if (off == OFF_REQ && data_ch == CHSEL_W'(c)) begin
               req_q[c] <= data_bit;
            end else if (is_mclr) begin
               req_q[c] <= 1'b0;
            end
            unique case (off)
               OFF_SMASK:   if (data_ch == CHSEL_W'(c)) mask_q[c] <= data_bit;
               OFF_ALLMASK: mask_q[c] <= wdata[c];
               OFF_CLRMASK: mask_q[c] <= 1'b0;
               OFF_MCLR:    mask_q[c] <= 1'b1;
               default:     ;
            endcase
         end
      end
   end

   // Command byte and byte pointer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
         ptr_q <= 1'b0;
      end else begin
         if (wr && off == OFF_CMD) cmd_q <= wdata;
         else if (is_mclr)         cmd_q <= '0;

         if (wr && (off == OFF_CLRPTR || off == OFF_MCLR)) ptr_q <= 1'b0;
         else if ((wr || rd) && pair_sel)                  ptr_q <= ~ptr_q;
      end
   end

   dsr_seq #(.LEN(SEQ_LEN)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr),
      .adv   (rd && en && off == OFF_CMD),
      .idx   (seq_idx)
   );

   // Readback selection
   always_comb begin
      logic [WORD_W-1:0] word;
      word       = '0;
      rdata      = '0;
      shadow_hit = 1'b0;
      if (pair_sel) begin
         shadow_hit = 1'b1;
         for (int c = 0; c < CHANNELS; c++) begin
            if (pair_ch == CHSEL_W'(c)) word = pair_cnt ? base_cnt_q[c] : base_addr_q[c];
         end
         rdata = ptr_q ? word[WORD_W-1:DATA_W] : word[DATA_W-1:0];
      end else if (off == OFF_CMD) begin
         shadow_hit = 1'b1;
         if (seq_idx == '0)                rdata = cmd_q;
         else if (seq_idx == SEQ_W'(1))    rdata = DATA_W'(req_q);
         else begin
            for (int c = 0; c < CHANNELS; c++) begin
               if (seq_idx == SEQ_W'(c + 2)) rdata = mode_q[c];
            end
         end
      end else if (off == OFF_ALLMASK) begin
         shadow_hit = 1'b1;
         rdata      = DATA_W'(mask_q);
      end
   end
endmodule

// File: rtl/dma_shadow_readback.sv
module dma_shadow_readback
   import dsr_pkg::*;
#(
   parameter int unsigned         ADDR_W    = 16,
   parameter int unsigned         DATA_W    = 8,
   parameter int unsigned         CHANNELS  = 4,
   parameter int unsigned         WORD_W    = 16,
   parameter logic [ADDR_W-1:0]   PRI_BASE  = 16'h0000,
   parameter logic [ADDR_W-1:0]   SEC_BASE  = 16'h00C0,
   parameter logic [ADDR_W-1:0]   SPAN_MASK = 16'hFFE0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              shadow_en,
   input  logic [DATA_W-1:0] ctrl_rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              shadow_active
);
   if ((PRI_BASE & ~SPAN_MASK) != '0 || (SEC_BASE & ~SPAN_MASK) != '0) begin : g_bad_base
      $error("dma_shadow_readback: bases must be aligned to SPAN_MASK");
   end
   if (PRI_BASE == SEC_BASE) begin : g_bad_overlap
      $error("dma_shadow_readback: controller windows overlap");
   end

   logic [CTRL_N-1:0] hit;
   logic [CTRL_N-1:0] sh_hit;
   logic [DATA_W-1:0] bank_rdata [CTRL_N];

   for (genvar k = 0; k < CTRL_N; k++) begin : g_ctl
      localparam logic [ADDR_W-1:0] BASE  = (k == 0) ? PRI_BASE : SEC_BASE;
      localparam int unsigned       SHIFT = (k == 0) ? 0 : 1;
      logic [OFF_W-1:0] off;

      dsr_decode #(
         .ADDR_W     (ADDR_W),
         .MATCH_MASK (SPAN_MASK),
         .MATCH_BASE (BASE),
         .SHIFT      (SHIFT)
      ) u_dec (
         .addr (io_addr),
         .hit  (hit[k]),
         .off  (off)
      );

      dsr_bank #(
         .CHANNELS (CHANNELS),
         .DATA_W   (DATA_W),
         .WORD_W   (WORD_W)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr         (io_wr && hit[k]),
         .rd         (io_rd && hit[k]),
         .en         (shadow_en),
         .off        (off),
         .wdata      (io_wdata),
         .rdata      (bank_rdata[k]),
         .shadow_hit (sh_hit[k])
      );
   end

   always_comb begin
      rd_data       = ctrl_rdata;
      shadow_active = 1'b0;
      if (io_rd && shadow_en) begin
         for (int k = 0; k < CTRL_N; k++) begin
            if (hit[k] && sh_hit[k]) begin
               rd_data       = bank_rdata[k];
               shadow_active = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] io_addr,
   input logic        io_rd,
   input logic        io_wr,
   input logic        shadow_en,
   input logic [7:0]  ctrl_rdata,
   input logic [7:0]  rd_data,
   input logic        shadow_active
);
   logic pri_hit;
   assign pri_hit = io_addr[15:5] == 11'd0;

   p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !shadow_en |-> (!shadow_active && rd_data == ctrl_rdata));

   p_write_native_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_rd) |-> (!shadow_active && rd_data == ctrl_rdata));

   p_pair_shadowed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && shadow_en && pri_hit && !io_addr[3]) |-> shadow_active);

   p_mask_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && shadow_en && pri_hit && io_addr[3:0] == 4'hF) |-> rd_data[7:4] == 4'h0);

   p_mclr_sets_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(io_wr && pri_hit && io_addr[3:0] == 4'hD) && io_rd && shadow_en
       && pri_hit && io_addr[3:0] == 4'hF) |-> rd_data[3:0] == 4'hF);

   p_other_native_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && pri_hit && io_addr[3:0] >= 4'h9 && io_addr[3:0] <= 4'hE)
      |-> (!shadow_active && rd_data == ctrl_rdata));
endmodule

bind dma_shadow_readback dsr_checker u_dsr_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .io_addr       (io_addr),
   .io_rd         (io_rd),
   .io_wr         (io_wr),
   .shadow_en     (shadow_en),
   .ctrl_rdata    (ctrl_rdata),
   .rd_data       (rd_data),
   .shadow_active (shadow_active)
);

// File: tb/dma_shadow_readback_bench.sv
`timescale 1ns/1ps
module dma_shadow_readback_bench;
   localparam logic [1:0] OP_N = 2'd0;  // native read, shadow enabled
   localparam logic [1:0] OP_W = 2'd1;  // write
   localparam logic [1:0] OP_S = 2'd2;  // shadow read
   localparam logic [1:0] OP_D = 2'd3;  // read with shadow disabled

   typedef struct packed {
      logic [1:0]  op;
      logic [3:0]  req;
      logic [15:0] addr;
      logic [7:0]  dat;
      logic [7:0]  exp;
   } vec_t;

   localparam int NV = 67;
   localparam vec_t VEC [NV] = '{
      '{OP_W, 4'd3,  16'h0000, 8'h34, 8'h00},  // R3 ch0 addr low
      '{OP_W, 4'd3,  16'h0000, 8'h12, 8'h00},  // R3 ch0 addr high
      '{OP_W, 4'd3,  16'h0003, 8'h78, 8'h00},  // R3 ch1 count low
      '{OP_W, 4'd3,  16'h0003, 8'h56, 8'h00},  // R3 ch1 count high
      '{OP_S, 4'd3,  16'h0000, 8'h00, 8'h34},  // R3
      '{OP_S, 4'd3,  16'h0010, 8'h00, 8'h12},  // R3 bit4 alias
      '{OP_S, 4'd3,  16'h0003, 8'h00, 8'h78},  // R3
      '{OP_S, 4'd3,  16'h0013, 8'h00, 8'h56},  // R3 alias
      '{OP_W, 4'd4,  16'h0000, 8'hAA, 8'h00},  // R4 ptr -> 1
      '{OP_W, 4'd4,  16'h000C, 8'h00, 8'h00},  // R4 clear ptr
      '{OP_S, 4'd4,  16'h0000, 8'h00, 8'hAA},  // R4
      '{OP_S, 4'd4,  16'h0000, 8'h00, 8'h12},  // R4
      '{OP_W, 4'd9,  16'h0008, 8'hC4, 8'h00},  // R9 command
      '{OP_W, 4'd7,  16'h0009, 8'h06, 8'h00},  // R7 set ch2
      '{OP_W, 4'd9,  16'h000B, 8'h45, 8'h00},  // R9 mode ch1
      '{OP_W, 4'd9,  16'h000B, 8'h8B, 8'h00},  // R9 mode ch3
      '{OP_W, 4'd7,  16'h0009, 8'h05, 8'h00},  // R7 set ch1
      '{OP_S, 4'd5,  16'h0008, 8'h00, 8'hC4},  // R5 command
      '{OP_S, 4'd5,  16'h0008, 8'h00, 8'h06},  // R5 request
      '{OP_S, 4'd5,  16'h0008, 8'h00, 8'h00},  // R5 mode0
      '{OP_S, 4'd5,  16'h0008, 8'h00, 8'h45},  // R5 mode1
      '{OP_S, 4'd5,  16'h0008, 8'h00, 8'h00},  // R5 mode2
      '{OP_S, 4'd5,  16'h0008, 8'h00, 8'h8B},  // R5 mode3
      '{OP_S, 4'd5,  16'h0008, 8'h00, 8'hC4},  // R5 wrap
      '{OP_S, 4'd5,  16'h0008, 8'h00, 8'h06},  // R5
      '{OP_W, 4'd6,  16'h000A, 8'h06, 8'h00},  // R6 write resets sequence
      '{OP_S, 4'd6,  16'h0008, 8'h00, 8'hC4},  // R6
      '{OP_S, 4'd8,  16'h000F, 8'h00, 8'h04},  // R8 single mask set
      '{OP_W, 4'd8,  16'h000F, 8'h0B, 8'h00},  // R8 write all
      '{OP_S, 4'd8,  16'h000F, 8'h00, 8'h0B},  // R8
      '{OP_W, 4'd8,  16'h000E, 8'h00, 8'h00},  // R8 clear mask
      '{OP_S, 4'd8,  16'h000F, 8'h00, 8'h00},  // R8
      '{OP_W, 4'd8,  16'h000A, 8'h07, 8'h00},  // R8 set ch3
      '{OP_W, 4'd8,  16'h000A, 8'h02, 8'h00},  // R8 clear ch2
      '{OP_S, 4'd8,  16'h000F, 8'h00, 8'h08},  // R8
      '{OP_W, 4'd7,  16'h0009, 8'h02, 8'h00},  // R7 clear ch2
      '{OP_S, 4'd7,  16'h0008, 8'h00, 8'hC4},  // R7
      '{OP_S, 4'd7,  16'h0008, 8'h00, 8'h02},  // R7
      '{OP_W, 4'd11, 16'h00C4, 8'h11, 8'h00},  // R11 sec ch1 addr low
      '{OP_W, 4'd11, 16'h00C5, 8'h22, 8'h00},  // R11 bit0 ignored
      '{OP_S, 4'd11, 16'h00C4, 8'h00, 8'h11},  // R11
      '{OP_S, 4'd11, 16'h00C5, 8'h00, 8'h22},  // R11
      '{OP_W, 4'd11, 16'h00D0, 8'h99, 8'h00},  // R11 sec command
      '{OP_S, 4'd11, 16'h00D1, 8'h00, 8'h99},  // R11
      '{OP_S, 4'd11, 16'h0008, 8'h00, 8'h00},  // R11 pri sequence kept (mode0)
      '{OP_S, 4'd11, 16'h00DE, 8'h00, 8'h00},  // R11 sec mask
      '{OP_W, 4'd11, 16'h00DE, 8'h0F, 8'h00},  // R11
      '{OP_S, 4'd11, 16'h00DE, 8'h00, 8'h0F},  // R11
      '{OP_S, 4'd11, 16'h000F, 8'h00, 8'h08},  // R11 pri mask kept
      '{OP_W, 4'd10, 16'h0000, 8'h5A, 8'h00},  // R10 ptr -> 1
      '{OP_W, 4'd10, 16'h000D, 8'h00, 8'h00},  // R10 master clear
      '{OP_S, 4'd10, 16'h000F, 8'h00, 8'h0F},  // R10
      '{OP_S, 4'd10, 16'h0008, 8'h00, 8'h00},  // R10 command cleared
      '{OP_S, 4'd10, 16'h0008, 8'h00, 8'h00},  // R10 request cleared
      '{OP_S, 4'd10, 16'h0008, 8'h00, 8'h00},  // R10 mode0
      '{OP_S, 4'd10, 16'h0008, 8'h00, 8'h45},  // R10 mode1 kept
      '{OP_S, 4'd10, 16'h0000, 8'h00, 8'h5A},  // R10 ptr cleared
      '{OP_S, 4'd10, 16'h0000, 8'h00, 8'h12},  // R10
      '{OP_D, 4'd4,  16'h0000, 8'h77, 8'h77},  // R4 native read toggles ptr
      '{OP_S, 4'd4,  16'h0000, 8'h00, 8'h12},  // R4
      '{OP_W, 4'd5,  16'h0008, 8'h3C, 8'h00},  // R5
      '{OP_D, 4'd1,  16'h0008, 8'h33, 8'h33},  // R1 no advance
      '{OP_S, 4'd1,  16'h0008, 8'h00, 8'h3C},  // R1
      '{OP_N, 4'd13, 16'h0009, 8'h5E, 8'h5E},  // R13
      '{OP_N, 4'd13, 16'h0100, 8'h61, 8'h61},  // R13 outside
      '{OP_N, 4'd13, 16'h00E0, 8'h62, 8'h62},  // R13 outside
      '{OP_N, 4'd13, 16'h000C, 8'h64, 8'h64}   // R13
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic        shadow_en = 1'b0;
   logic [7:0]  ctrl_rdata = '0;
   logic [7:0]  rd_data;
   logic        shadow_active;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dma_shadow_readback u_dma_shadow_readback (
      .clk           (clk),
      .rst_n         (rst_n),
      .io_addr       (io_addr),
      .io_wr         (io_wr),
      .io_rd         (io_rd),
      .io_wdata      (io_wdata),
      .shadow_en     (shadow_en),
      .ctrl_rdata    (ctrl_rdata),
      .rd_data       (rd_data),
      .shadow_active (shadow_active)
   );

   task automatic check(input int req, input logic ok, input logic [8:0] act,
                        input logic [8:0] exp, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input int req, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
      shadow_en = 1'b1; ctrl_rdata = 8'hE7;
      #1;
      // R2: writes are never redirected
      check(2, !shadow_active && rd_data == 8'hE7, {shadow_active, rd_data}, 9'h0E7,
            $sformatf("write %h (from R%0d)", a, req));
      @(posedge clk); #1;
      io_wr = 1'b0;
   endtask

   task automatic do_read(input logic [1:0] op, input int req, input logic [15:0] a,
                          input logic [7:0] d, input logic [7:0] e);
      logic exp_act;
      @(negedge clk);
      io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
      shadow_en  = (op != OP_D);
      ctrl_rdata = (op == OP_S) ? 8'hE7 : d;
      exp_act    = (op == OP_S);
      #1;
      check(req, rd_data == e && shadow_active == exp_act, {shadow_active, rd_data},
            {exp_act, e}, $sformatf("read %h", a));
      @(posedge clk); #1;
      io_rd = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; io_wr = 1'b0; io_rd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R12: reset state
      do_read(OP_S, 12, 16'h0000, 8'h00, 8'h00);
      do_read(OP_S, 12, 16'h000F, 8'h00, 8'h00);
      do_read(OP_S, 12, 16'h0008, 8'h00, 8'h00);
      do_read(OP_S, 12, 16'h00C6, 8'h00, 8'h00);
      // clean restart so table starts from pointer 0
      do_reset();
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].op == OP_W) do_write(int'(VEC[i].req), VEC[i].addr, VEC[i].dat);
         else do_read(VEC[i].op, int'(VEC[i].req), VEC[i].addr, VEC[i].dat, VEC[i].exp);
      end
      // R12: mid-run reset clears all contents
      do_reset();
      do_read(OP_S, 12, 16'h0003, 8'h00, 8'h00);
      do_read(OP_S, 12, 16'h0008, 8'h00, 8'h00);
      do_read(OP_S, 12, 16'h00C4, 8'h00, 8'h00);
      do_read(OP_S, 12, 16'h00D0, 8'h00, 8'h00);
      do_read(OP_S, 12, 16'h000F, 8'h00, 8'h00);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL R0 watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule